// File: doc/BRIEF.md
# Governed Predicate Logic Unit

This unit computes bitwise logic on two predicate operands, `pn` and `pm`. Each operation is masked by a governing predicate `pg`, and the result goes to a destination predicate. A predicate holds one bit per vector byte. The widest predicate is set by a parameter, and the `cfg_len` input gives the number of predicate bits that are live for the current vector length.

With flag-setting enabled, the unit also produces N, Z, C and V. It derives them from the result, looking only at the elements that `pg` marks active for the chosen element size. A separate test operation computes the same flags directly from `pn` under `pg` and writes no destination.

Operations are issued one per cycle with `op_valid`. Every output is registered and appears one cycle after issue. The register file that holds the operands is outside this block. So the flags always see the governing value presented with the operation, even when the caller writes the result back over that same register.

Top module: `gpl_unit`

## Requirements
- R1: op_sel 0 gives (pn & pm) & pg, op_sel 2 gives (pn ^ pm) & pg, and op_sel 4 gives (pn | pm) & pg.
- R2: op_sel 1 gives (pn & ~pm) & pg, and op_sel 5 gives (pn | ~pm) & pg.
- R3: op_sel 6 gives pg & ~(pn | pm), and op_sel 7 gives pg & ~(pn & pm).
- R4: op_sel 3 selects pn where pg is 1 and pm where pg is 0. Two cases are undefined: op_sel 3 with set_flags high, and any op_sel from 9 to 15. An undefined operation raises `undef` for one cycle and writes neither the result nor the flags.
- R5: Outputs are registered and appear one cycle after an issue cycle (op_valid high). `res_we` and `flags_we` are high only in that cycle. `res` holds its value between writes. Synchronous reset clears `res` and every strobe.
- R6: With flags written, N equals the result bit at the lowest active element.
- R7: With flags written, Z is 1 exactly when no active element of the result is 1.
- R8: With flags written, C is the inverse of the result bit at the highest active element. When no element is active, the flags are N=0, Z=1, C=1.
- R9: Every flag write clears V.
- R10: An element is active where pg is 1 and the bit index fits the element size. esz 0 accepts every index, esz 1 every index divisible by 2, esz 2 every index divisible by 4, and esz 3 every index divisible by 8.
- R11: op_sel 8 is a test. It writes the flags computed from pn under pg, whatever the value of set_flags, and writes no result.
- R12: Result bits at indices at or above cfg_len are 0, and those indices are never active for the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_sel | input | 4 | Operation code (see R1 to R4 and R11) |
| set_flags | input | 1 | Also produce flags from the result |
| esz | input | 2 | Element size code (see R10) |
| cfg_len | input | $clog2(MAX_PW+1) | Number of live predicate bits |
| pn | input | MAX_PW | First predicate operand |
| pm | input | MAX_PW | Second predicate operand |
| pg | input | MAX_PW | Governing predicate |
| res | output | MAX_PW | Result predicate |
| res_we | output | 1 | Result write strobe |
| flag_n | output | 1 | Negative / first-active flag |
| flag_z | output | 1 | Zero / none-active flag |
| flag_c | output | 1 | Carry / not-last-active flag |
| flag_v | output | 1 | Overflow flag, cleared on every flag write |
| flags_we | output | 1 | Flag write strobe |
| undef | output | 1 | Undefined operation, nothing written |

## Verification
The assertions assume that the inputs sampled in an issue cycle are the ones the registered outputs reflect one cycle later. They take `$past` of `pg` and `cfg_len` on that basis, and they assume that `cfg_len` never exceeds `MAX_PW`. The stimulus changes inputs only at the falling edge, holds each operation for exactly one cycle, and then drops `op_valid` before the outputs are sampled. Every `cfg_len` it uses is 16 or 8, which stays within the width.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
  localparam logic [3:0] OP_AND  = 4'd0;
  localparam logic [3:0] OP_BIC  = 4'd1;
  localparam logic [3:0] OP_EOR  = 4'd2;
  localparam logic [3:0] OP_SEL  = 4'd3;
  localparam logic [3:0] OP_ORR  = 4'd4;
  localparam logic [3:0] OP_ORN  = 4'd5;
  localparam logic [3:0] OP_NOR  = 4'd6;
  localparam logic [3:0] OP_NAND = 4'd7;
  localparam logic [3:0] OP_TEST = 4'd8;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } gpl_flags_t;
endpackage

// File: rtl/gpl_bitop.sv
module gpl_bitop
  import gpl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] g,
  output logic [W-1:0] r
);
  always_comb begin
    case (op)
      OP_AND:  r = a & b & g;
      OP_BIC:  r = a & ~b & g;
      OP_EOR:  r = (a ^ b) & g;
      OP_SEL:  r = (a & g) | (b & ~g);
      OP_ORR:  r = (a | b) & g;
      OP_ORN:  r = (a | ~b) & g;
      OP_NOR:  r = g & ~(a | b);
      OP_NAND: r = g & ~(a & b);
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/gpl_lane_mask.sv
module gpl_lane_mask #(
  parameter int W  = 16,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [1:0]    esz,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  mask
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    localparam logic [LW-1:0] IDX = LW'(i);
    localparam bit STEP2 = (i % 2) == 0;
    localparam bit STEP4 = (i % 4) == 0;
    localparam bit STEP8 = (i % 8) == 0;
    logic size_ok;
    always_comb begin
      case (esz)
        2'd0:    size_ok = 1'b1;
        2'd1:    size_ok = STEP2;
        2'd2:    size_ok = STEP4;
        default: size_ok = STEP8;
      endcase
    end
    assign mask[i] = (IDX < len) && size_ok;
  end
endmodule

// File: rtl/gpl_flag_eval.sv
module gpl_flag_eval
  import gpl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] act,
  output gpl_flags_t   flags
);
  always_comb begin
    logic seen;
    seen    = 1'b0;
    flags.n = 1'b0;
    flags.c = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (act[i]) begin
        if (!seen) flags.n = val[i];
        seen    = 1'b1;
        flags.c = !val[i];
      end
    end
    flags.z = ~|(val & act);
    flags.v = 1'b0;
  end
endmodule

// File: rtl/gpl_unit.sv
module gpl_unit
  import gpl_pkg::*;
#(
  parameter int MAX_PW = 16,
  localparam int LW = $clog2(MAX_PW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_sel,
  input  logic              set_flags,
  input  logic [1:0]        esz,
  input  logic [LW-1:0]     cfg_len,
  input  logic [MAX_PW-1:0] pn,
  input  logic [MAX_PW-1:0] pm,
  input  logic [MAX_PW-1:0] pg,
  output logic [MAX_PW-1:0] res,
  output logic              res_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flags_we,
  output logic              undef
);
  logic [MAX_PW-1:0] raw_res, live_mask, elem_mask, next_res, flag_src;
  gpl_flags_t        next_flags, flags_q;
  logic              is_test, legal, do_res, do_flags;

  gpl_bitop #(.W(MAX_PW)) u_op (
    .op(op_sel), .a(pn), .b(pm), .g(pg), .r(raw_res)
  );

  gpl_lane_mask #(.W(MAX_PW), .LW(LW)) u_live (
    .esz(2'd0), .len(cfg_len), .mask(live_mask)
  );

  gpl_lane_mask #(.W(MAX_PW), .LW(LW)) u_elem (
    .esz(esz), .len(cfg_len), .mask(elem_mask)
  );

  assign next_res = raw_res & live_mask;
  assign is_test  = (op_sel == OP_TEST);
  assign flag_src = is_test ? (pn & live_mask) : next_res;

  gpl_flag_eval #(.W(MAX_PW)) u_flags (
    .val(flag_src), .act(pg & elem_mask), .flags(next_flags)
  );

  assign legal    = (op_sel <= OP_TEST) && !((op_sel == OP_SEL) && set_flags);
  assign do_res   = op_valid && legal && !is_test;
  assign do_flags = op_valid && legal && (is_test || set_flags);

  always_ff @(posedge clk) begin
    if (rst) begin
      res      <= '0;
      res_we   <= 1'b0;
      flags_we <= 1'b0;
      undef    <= 1'b0;
      flags_q  <= '0;
    end else begin
      res_we   <= do_res;
      flags_we <= do_flags;
      undef    <= op_valid && !legal;
      if (do_res)   res     <= next_res;
      if (do_flags) flags_q <= next_flags;
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
endmodule

// File: rtl/gpl_unit_chk.sv
module gpl_unit_chk #(
  parameter int MAX_PW = 16,
  localparam int LW = $clog2(MAX_PW + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_sel,
  input logic              set_flags,
  input logic [1:0]        esz,
  input logic [LW-1:0]     cfg_len,
  input logic [MAX_PW-1:0] pn,
  input logic [MAX_PW-1:0] pm,
  input logic [MAX_PW-1:0] pg,
  input logic [MAX_PW-1:0] res,
  input logic              res_we,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v,
  input logic              flags_we,
  input logic              undef
);
  a_r9_v_clear: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> !flag_v);

  a_r4_undef_no_write: assert property (@(posedge clk) disable iff (rst)
    undef |-> (!res_we && !flags_we));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(op_valid) |-> (!res_we && !flags_we && !undef));

  a_r5_res_hold: assert property (@(posedge clk) disable iff (rst)
    !res_we |-> $stable(res));

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (rst)
    res_we |-> ((res >> $past(cfg_len)) == '0));

  a_r7_z_when_empty: assert property (@(posedge clk) disable iff (rst)
    (flags_we && res_we && ((res & $past(pg)) == '0)) |-> flag_z);

  a_r6_n_excludes_z: assert property (@(posedge clk) disable iff (rst)
    (flags_we && flag_n) |-> !flag_z);

  a_r11_test_no_result: assert property (@(posedge clk) disable iff (rst)
    (flags_we && !$past(set_flags)) |-> !res_we);
endmodule

bind gpl_unit gpl_unit_chk #(.MAX_PW(MAX_PW)) u_chk (.*);

// File: tb/tb_gpl_unit.sv
`timescale 1ns/1ps
module tb_gpl_unit;
  localparam int PW = 16;
  localparam int LW = $clog2(PW + 1);

  typedef struct packed {
    logic [3:0]    op;
    logic          sf;
    logic [1:0]    esz;
    logic [LW-1:0] len;
    logic [PW-1:0] n;
    logic [PW-1:0] m;
    logic [PW-1:0] g;
    logic [PW-1:0] xres;
    logic [3:0]    xnzcv;
    logic          xwe;
    logic          xfwe;
    logic          xund;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h000C, 4'b1010, 1'b1, 1'b1, 1'b0},
    '{4'd4, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h0C3C, 4'b1010, 1'b1, 1'b1, 1'b0},
    '{4'd2, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h0C30, 4'b0010, 1'b1, 1'b1, 1'b0},
    '{4'd1, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h0030, 4'b0010, 1'b1, 1'b1, 1'b0},
    '{4'd5, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h303C, 4'b1000, 1'b1, 1'b1, 1'b0},
    '{4'd6, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h3000, 4'b0000, 1'b1, 1'b1, 1'b0},
    '{4'd7, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h3C30, 4'b0000, 1'b1, 1'b1, 1'b0},
    '{4'd3, 1'b0, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h033F, 4'b0000, 1'b1, 1'b0, 1'b0},
    '{4'd3, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h0000, 4'b0000, 1'b0, 1'b0, 1'b1},
    '{4'd9, 1'b0, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h0000, 4'b0000, 1'b0, 1'b0, 1'b1},
    '{4'd8, 1'b0, 2'd0, 5'd16, 16'h00FF, 16'h0000, 16'h3C3C, 16'h0000, 4'b1010, 1'b0, 1'b1, 1'b0},
    '{4'd8, 1'b1, 2'd0, 5'd16, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 4'b0110, 1'b0, 1'b1, 1'b0},
    '{4'd8, 1'b0, 2'd2, 5'd16, 16'h2222, 16'h0000, 16'hFFFF, 16'h0000, 4'b0110, 1'b0, 1'b1, 1'b0},
    '{4'd8, 1'b0, 2'd3, 5'd16, 16'h0100, 16'h0000, 16'hFFFF, 16'h0000, 4'b0000, 1'b0, 1'b1, 1'b0},
    '{4'd8, 1'b0, 2'd1, 5'd16, 16'h4000, 16'h0000, 16'h7FFE, 16'h0000, 4'b0000, 1'b0, 1'b1, 1'b0},
    '{4'd4, 1'b1, 2'd0, 5'd8,  16'hFFFF, 16'h0000, 16'hFFFF, 16'h00FF, 4'b1000, 1'b1, 1'b1, 1'b0},
    '{4'd8, 1'b0, 2'd0, 5'd8,  16'hFF00, 16'h0000, 16'hFFFF, 16'h0000, 4'b0110, 1'b0, 1'b1, 1'b0},
    '{4'd0, 1'b0, 2'd0, 5'd16, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'h000C, 4'b0000, 1'b1, 1'b0, 1'b0}
  };
  localparam string TAG [NV] = '{
    "R1 and", "R1 orr", "R1 eor", "R2 bic", "R2 orn", "R3 nor", "R3 nand",
    "R4 sel", "R4 sel-flags undefined", "R4 reserved opcode",
    "R11 test", "R8 no active", "R10 esz2", "R10 esz3 R8", "R10 esz1 R6",
    "R12 short length", "R12 test short", "R1 plain and"
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [3:0] op_sel = '0;
  logic set_flags = 1'b0;
  logic [1:0] esz = '0;
  logic [LW-1:0] cfg_len = LW'(PW);
  logic [PW-1:0] pn = '0, pm = '0, pg = '0;
  logic [PW-1:0] res;
  logic res_we, flag_n, flag_z, flag_c, flag_v, flags_we, undef;

  int n_checks = 0;
  int n_fails = 0;

  always #2 clk = ~clk;

  gpl_unit #(.MAX_PW(PW)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .set_flags(set_flags), .esz(esz), .cfg_len(cfg_len),
    .pn(pn), .pm(pm), .pg(pg), .res(res), .res_we(res_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .flags_we(flags_we), .undef(undef)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    op_sel = v.op; set_flags = v.sf; esz = v.esz; cfg_len = v.len;
    pn = v.n; pm = v.m; pg = v.g; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 reset res", 32'(res), 32'h0);
    chk("R5 reset strobes", {29'd0, res_we, flags_we, undef}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 idle after reset", {29'd0, res_we, flags_we, undef}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i]);
      chk({TAG[i], " res_we"}, 32'(res_we), 32'(TBL[i].xwe));
      chk({TAG[i], " flags_we"}, 32'(flags_we), 32'(TBL[i].xfwe));
      chk({TAG[i], " undef"}, 32'(undef), 32'(TBL[i].xund));
      if (TBL[i].xwe) chk({TAG[i], " result"}, 32'(res), 32'(TBL[i].xres));
      if (TBL[i].xfwe)
        chk({TAG[i], " NZCV (R6 R7 R8 R9)"}, {28'd0, flag_n, flag_z, flag_c, flag_v},
            {28'd0, TBL[i].xnzcv});
    end

    // R5: strobes last one cycle and the result holds while idle
    @(negedge clk);
    chk("R5 strobes drop", {29'd0, res_we, flags_we, undef}, 32'h0);
    chk("R5 result held", 32'(res), 32'h000C);

    // R4: an undefined op leaves the held result untouched
    issue(TBL[9]);
    chk("R4 undefined keeps result", 32'(res), 32'h000C);

    // R11: test op leaves the result untouched
    issue(TBL[10]);
    chk("R11 test keeps result", 32'(res), 32'h000C);

    // R5: synchronous reset mid-run clears result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R5 reset clears result", 32'(res), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule